// File: doc/BRIEF.md
# Power-State Controller for a Multi-Rail Regulator Chip

This block is the digital controller that decides which of the chip's six output rails (four buck converters and two linear regulators) are enabled, and whether each buck runs in automatic pulse-skipping mode or in forced PWM. It watches the enable pin, an input-supply-good flag and three host control pins: hold, low-power and performance. From these it moves between OFF, a start-up sequence, Active, Low-Power, High-Performance and Hibernate. It drives the rail enables, the buck mode selects, a reset-output drive, a wake pulse toward the host, a sequence-done flag, a sticky illegal-request flag and the current power state.

Start-up switches the rails on one at a time in a fixed order, with a programmable interval between them. The host must confirm a start-up by holding the hold pin high before the sequence ends; otherwise the controller falls back to OFF. When the supply returns while hold is low, the controller restarts on its own and pulses the wake output so the host can confirm. The performance pin is ignored until software has set an unmask bit through the register-write port, and that write only counts once the sequence-done flag is set.

Top module: `pmic_pwr_ctrl`

## Requirements
- R1: After reset the controller is in OFF (`pwr_state`=0), with all rails off, `rst_drive_low`=1, and `seq_done`, `wake_pulse` and `illegal_err` all 0. It leaves OFF only on a rising edge of the condition "enable pin high and `vin_ok` high"; the condition counts as low at reset.
- R2: In the start-up state (`pwr_state`=1), rail bit k turns on k*`seq_step` cycles after the cycle the state is entered, in the order bit0..bit3 = buck1..buck4, bit4 = LDO1, bit5 = LDO2. A `seq_step` of 0 acts as 1. During the sequence all `buck_fpwm` bits are 1 and `rst_drive_low` is 1.
- R3: `seq_done` rises on the same edge that the last rail turns on. On the following edge the controller goes to Active if hold is high, or else to OFF. `seq_done` is cleared on entry to OFF and at the start of each sequence.
- R4: In the stable states, the code {hold, low-power, masked performance} selects the state: 000 OFF(0), 010 Hibernate(5), 110 Low-Power(3), 100 Active(2), 101 High-Performance(4). Active and High-Performance have all rails on, `buck_fpwm`=1111 and `rst_drive_low`=0. Low-Power has all rails on, `buck_fpwm`=0000 and `rst_drive_low`=0. Hibernate has only rail bit1 on, `buck_fpwm`=0000 and `rst_drive_low`=1.
- R5: The controller never enters Low-Power directly from OFF. A start-up with low-power high shows Active for one cycle, then Low-Power.
- R6: The performance pin is seen as 0 until the unmask bit is set. A write (`reg_wr`=1, `reg_wdata`=1) sets the bit only when `seq_done` is 1, and writing 0 has no effect.
- R7: The unmask bit is cleared by reset, or by a falling edge of the synchronized enable pin while in OFF.
- R8: Any other code seen in Active, Low-Power, High-Performance or Hibernate leaves the state unchanged and sets `illegal_err`, which stays set until reset.
- R9: In Hibernate, hold going high starts the sequence again.
- R10: A start from OFF while hold is low drives `wake_pulse` high for exactly WAKE_LEN cycles, starting on the edge that enters the sequence. If hold is still low when the sequence ends, the controller returns to OFF and does not restart until the start condition rises again.
- R11: Enable pin low or `vin_ok` low forces OFF from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| en_pin | input | 1 | Chip enable pin (asynchronous) |
| vin_ok | input | 1 | Input supply above undervoltage threshold (synchronous) |
| hold_pin | input | 1 | Host hold / confirm pin (asynchronous) |
| lowpwr_pin | input | 1 | Low-power request pin (asynchronous) |
| perf_pin | input | 1 | Performance request pin (asynchronous) |
| reg_wr | input | 1 | Write strobe for the unmask bit |
| reg_wdata | input | 1 | Value written to the unmask bit |
| seq_step | input | STEP_W | Cycles between successive rail enables |
| rail_en | output | 6 | Rail enables, bit0..3 buck1..4, bit4..5 LDO1..2 |
| buck_fpwm | output | 4 | Per-buck mode: 1 forced PWM, 0 auto pulse-skipping |
| rst_drive_low | output | 1 | 1 drives the reset output low, 0 releases it |
| wake_pulse | output | 1 | Wake event toward the host |
| seq_done | output | 1 | Start-up sequence complete |
| illegal_err | output | 1 | Sticky illegal-request flag |
| pwr_state | output | 3 | Current power state code |

## Verification
The hold, low-power, performance and enable pins pass through two flops, so the state reacts on the third rising edge after a pin changes. A change on `vin_ok` acts on the next edge, and an unmask write affects decoding one edge after the write edge. Rail k appears k*`seq_step` edges after the sequence-entry edge, and the move out of the sequence comes one edge after `seq_done`. The bench drives inputs on falling edges and samples on the falling edge after exactly the counted number of rising edges. Where the count matters it checks both the cycle before and the cycle of the change; otherwise it waits past the latency before it samples.

// File: rtl/pmic_pkg.sv
package pmic_pkg;

    localparam int NUM_BUCK = 4;
    localparam int NUM_LDO  = 2;
    localparam int NUM_RAIL = NUM_BUCK + NUM_LDO;
    localparam int CNT_W    = $clog2(NUM_RAIL + 1);

    typedef enum logic [2:0] {
        PS_OFF    = 3'd0,
        PS_SEQ    = 3'd1,
        PS_ACTIVE = 3'd2,
        PS_LOWPWR = 3'd3,
        PS_HIPERF = 3'd4,
        PS_HIBER  = 3'd5
    } pstate_e;

    typedef struct packed {
        logic hold;
        logic lowpwr;
        logic perf;
    } ctrl_t;

    typedef struct packed {
        logic    valid;
        pstate_e target;
    } decode_t;

    typedef struct packed {
        logic [NUM_RAIL-1:0] rails;
        logic [NUM_BUCK-1:0] fpwm;
        logic                rst_low;
    } drive_t;

    // Map a control code (performance already masked) to a target state.
    function automatic decode_t decode_ctrl(ctrl_t c);
        decode_t r;
        r.valid  = 1'b1;
        r.target = PS_OFF;
        unique case ({c.hold, c.lowpwr, c.perf})
            3'b000:  r.target = PS_OFF;
            3'b010:  r.target = PS_HIBER;
            3'b110:  r.target = PS_LOWPWR;
            3'b100:  r.target = PS_ACTIVE;
            3'b101:  r.target = PS_HIPERF;
            default: r.valid  = 1'b0;
        endcase
        return r;
    endfunction

    // Lowest n rails on.
    function automatic logic [NUM_RAIL-1:0] first_rails(logic [CNT_W-1:0] n);
        logic [NUM_RAIL-1:0] m;
        for (int i = 0; i < NUM_RAIL; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    function automatic drive_t drive_for(pstate_e s, logic [CNT_W-1:0] n);
        drive_t d;
        d.rails   = '0;
        d.fpwm    = '0;
        d.rst_low = 1'b1;
        unique case (s)
            PS_SEQ: begin
                d.rails = first_rails(n);
                d.fpwm  = '1;
            end
            PS_ACTIVE, PS_HIPERF: begin
                d.rails   = '1;
                d.fpwm    = '1;
                d.rst_low = 1'b0;
            end
            PS_LOWPWR: begin
                d.rails   = '1;
                d.rst_low = 1'b0;
            end
            PS_HIBER: begin
                d.rails[1] = 1'b1;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pmic_sync.sv
module pmic_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                stab_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= d[i];
                stab_q[i] <= meta_q[i];
            end
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/pmic_seq.sv
module pmic_seq
    import pmic_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic              clr,
    input  logic [STEP_W-1:0] step,
    output logic [CNT_W-1:0]  rail_cnt,
    output logic              done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_RAIL);

    logic [STEP_W-1:0] tmr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              tick_end;

    assign tick_end = (step == '0) || (tmr_q >= step - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            tmr_q  <= '0;
            cnt_q  <= CNT_W'(1);
            done_q <= 1'b0;
        end else if (clr) begin
            tmr_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (run && cnt_q != LAST) begin
            if (tick_end) begin
                tmr_q <= '0;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST - 1'b1) begin
                    done_q <= 1'b1;
                end
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign rail_cnt = cnt_q;
    assign done     = done_q;

    // R3
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (cnt_q == LAST));
endmodule

// File: rtl/pmic_fsm.sv
module pmic_fsm
    import pmic_pkg::*;
#(
    parameter int WAKE_LEN = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en_s,
    input  logic    vin_ok,
    input  ctrl_t   ctrl_s,
    input  logic    reg_wr,
    input  logic    reg_wdata,
    input  logic    seq_done,
    output pstate_e state,
    output logic    seq_start,
    output logic    wake,
    output logic    err
);
    localparam int WAKE_W = $clog2(WAKE_LEN + 1);

    pstate_e           state_q, state_d;
    logic              start_prev_q;
    logic              en_prev_q;
    logic              unmask_q;
    logic              err_q;
    logic [WAKE_W-1:0] wake_q;
    logic              start_edge;
    logic              err_set;
    logic              wake_start;
    ctrl_t             eff;
    decode_t           dec;

    assign start_edge = en_s && vin_ok && !start_prev_q;

    always_comb begin
        eff      = ctrl_s;
        eff.perf = ctrl_s.perf && unmask_q;
        dec      = decode_ctrl(eff);
    end

    always_comb begin
        state_d    = state_q;
        err_set    = 1'b0;
        wake_start = 1'b0;
        if (!en_s || !vin_ok) begin
            state_d = PS_OFF;
        end else begin
            unique case (state_q)
                PS_OFF: begin
                    if (start_edge) begin
                        state_d    = PS_SEQ;
                        wake_start = !ctrl_s.hold;
                    end
                end
                PS_SEQ: begin
                    if (seq_done) begin
                        state_d = ctrl_s.hold ? PS_ACTIVE : PS_OFF;
                    end
                end
                PS_HIBER: begin
                    if (ctrl_s.hold) begin
                        state_d = PS_SEQ;
                    end else if (dec.valid) begin
                        state_d = dec.target;
                    end else begin
                        err_set = 1'b1;
                    end
                end
                default: begin
                    if (dec.valid) begin
                        state_d = dec.target;
                    end else begin
                        err_set = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= PS_OFF;
            start_prev_q <= 1'b0;
            en_prev_q    <= 1'b0;
            unmask_q     <= 1'b0;
            err_q        <= 1'b0;
            wake_q       <= '0;
        end else begin
            state_q      <= state_d;
            start_prev_q <= en_s && vin_ok;
            en_prev_q    <= en_s;
            if (err_set) begin
                err_q <= 1'b1;
            end
            if (state_q == PS_OFF && en_prev_q && !en_s) begin
                unmask_q <= 1'b0;
            end else if (reg_wr && reg_wdata && seq_done) begin
                unmask_q <= 1'b1;
            end
            if (wake_start) begin
                wake_q <= WAKE_W'(WAKE_LEN);
            end else if (wake_q != '0) begin
                wake_q <= wake_q - 1'b1;
            end
        end
    end

    assign state     = state_q;
    assign seq_start = (state_q != PS_SEQ) && (state_d == PS_SEQ);
    assign wake      = (wake_q != '0);
    assign err       = err_q;

    // R5
    off_not_lowpwr_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_OFF) |=> (state_q != PS_LOWPWR));
    // R6
    unmask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unmask_q) |-> $past(seq_done));
    // R8
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> (state_q == $past(state_q)));
    // R10
    wake_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake) |-> (state_q == PS_SEQ));
    // R1
    leave_off_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_OFF && !(en_s && vin_ok)) |=> (state_q == PS_OFF));
endmodule

// File: rtl/pmic_rail_drv.sv
module pmic_rail_drv
    import pmic_pkg::*;
(
    input  pstate_e             state,
    input  logic [CNT_W-1:0]    rail_cnt,
    output logic [NUM_RAIL-1:0] rails,
    output logic [NUM_BUCK-1:0] fpwm,
    output logic                rst_low
);
    drive_t drv;

    always_comb begin
        drv     = drive_for(state, rail_cnt);
        rails   = drv.rails;
        fpwm    = drv.fpwm;
        rst_low = drv.rst_low;
    end
endmodule

// File: rtl/pmic_pwr_ctrl.sv
module pmic_pwr_ctrl
    import pmic_pkg::*;
#(
    parameter int STEP_W   = 8,
    parameter int WAKE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_pin,
    input  logic              vin_ok,
    input  logic              hold_pin,
    input  logic              lowpwr_pin,
    input  logic              perf_pin,
    input  logic              reg_wr,
    input  logic              reg_wdata,
    input  logic [STEP_W-1:0] seq_step,
    output logic [5:0]        rail_en,
    output logic [3:0]        buck_fpwm,
    output logic              rst_drive_low,
    output logic              wake_pulse,
    output logic              seq_done,
    output logic              illegal_err,
    output logic [2:0]        pwr_state
);
    logic [3:0]       pins_s;
    ctrl_t            ctrl_s;
    logic             en_s;
    pstate_e          state;
    logic             seq_start;
    logic             done;
    logic [CNT_W-1:0] rail_cnt;

    pmic_sync #(.W(4)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({en_pin, hold_pin, lowpwr_pin, perf_pin}),
        .q   (pins_s)
    );

    assign en_s   = pins_s[3];
    assign ctrl_s = ctrl_t'(pins_s[2:0]);

    pmic_fsm #(.WAKE_LEN(WAKE_LEN)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .en_s      (en_s),
        .vin_ok    (vin_ok),
        .ctrl_s    (ctrl_s),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .seq_done  (done),
        .state     (state),
        .seq_start (seq_start),
        .wake      (wake_pulse),
        .err       (illegal_err)
    );

    pmic_seq #(.STEP_W(STEP_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .run      (state == PS_SEQ),
        .clr      (state == PS_OFF),
        .step     (seq_step),
        .rail_cnt (rail_cnt),
        .done     (done)
    );

    pmic_rail_drv drv_i (
        .state    (state),
        .rail_cnt (rail_cnt),
        .rails    (rail_en),
        .fpwm     (buck_fpwm),
        .rst_low  (rst_drive_low)
    );

    assign seq_done  = done;
    assign pwr_state = state;

    // R2
    seq_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SEQ && $past(state == PS_SEQ))
            |-> ((rail_en & $past(rail_en)) == $past(rail_en)));
    // R3
    done_all_on_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> (rail_en == 6'b111111));
    // R4
    hiber_rails_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_HIBER) |-> (rail_en == 6'b000010 && rst_drive_low));
    // R11
    supply_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !vin_ok |=> (state == PS_OFF));
endmodule

// File: tb/pmic_pwr_ctrl_tb.sv
module pmic_pwr_ctrl_tb_top;
    localparam int STEP_W   = 8;
    localparam int WAKE_LEN = 4;
    localparam int STEP     = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, vin = 1'b0, hold = 1'b0, lp = 1'b0, perf = 1'b0;
    logic wr = 1'b0, wd = 1'b0;
    logic [STEP_W-1:0] step = STEP_W'(STEP);
    logic [5:0] rail_en;
    logic [3:0] buck_fpwm;
    logic rst_low, wake, sdone, err;
    logic [2:0] pst;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pmic_pwr_ctrl #(.STEP_W(STEP_W), .WAKE_LEN(WAKE_LEN)) dut_i (
        .clk(clk), .rst(rst), .en_pin(en), .vin_ok(vin), .hold_pin(hold),
        .lowpwr_pin(lp), .perf_pin(perf), .reg_wr(wr), .reg_wdata(wd),
        .seq_step(step), .rail_en(rail_en), .buck_fpwm(buck_fpwm),
        .rst_drive_low(rst_low), .wake_pulse(wake), .seq_done(sdone),
        .illegal_err(err), .pwr_state(pst)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        en = 1'b1; hold = 1'b1;
        tick(3);
        rst = 1'b0;
        chk("R1", "state after reset", pst, 0);
        chk("R1", "rails after reset", rail_en, 0);
        chk("R1", "reset drive", rst_low, 1);
        chk("R1", "flags", {sdone, wake, err}, 0);
        tick(6);
        chk("R1", "stays off while vin low", pst, 0);
    endtask

    task automatic t_powerup();
        vin = 1'b1;
        tick(1);
        chk("R2", "seq entered", pst, 1);
        chk("R2", "first rail", rail_en, 1);
        chk("R2", "fpwm in seq", buck_fpwm, 15);
        chk("R10", "no wake when hold high", wake, 0);
        wr = 1'b1; wd = 1'b1;
        for (int k = 1; k < 6; k++) begin
            tick(STEP - 1);
            wr = 1'b0;
            chk("R2", $sformatf("rails before step %0d", k), rail_en, (1 << k) - 1);
            tick(1);
            chk("R2", $sformatf("rails at step %0d", k), rail_en, (1 << (k + 1)) - 1);
        end
        chk("R3", "done with last rail", sdone, 1);
        chk("R2", "reset low in seq", rst_low, 1);
        tick(1);
        chk("R3", "active after done", pst, 2);
        chk("R4", "active reset released", rst_low, 0);
        chk("R4", "active fpwm", buck_fpwm, 15);
    endtask

    task automatic t_hpm_masked();
        perf = 1'b1;
        tick(4);
        chk("R6", "perf masked, early write ignored", pst, 2);
        chk("R8", "masked perf not illegal", err, 0);
        lp = 1'b1;
        tick(4);
        chk("R4", "low-power state", pst, 3);
        chk("R4", "low-power fpwm", buck_fpwm, 0);
        chk("R4", "low-power rails", rail_en, 63);
        lp = 1'b0;
        tick(4);
        chk("R4", "back to active", pst, 2);
    endtask

    task automatic t_unmask();
        wr = 1'b1; wd = 1'b0;
        tick(1);
        wr = 1'b0;
        tick(2);
        chk("R6", "write of zero ignored", pst, 2);
        wr = 1'b1; wd = 1'b1;
        tick(1);
        wr = 1'b0;
        chk("R6", "state on write edge", pst, 2);
        tick(1);
        chk("R6", "high-performance after unmask", pst, 4);
    endtask

    task automatic t_illegal();
        lp = 1'b1;
        tick(4);
        chk("R8", "illegal keeps state", pst, 4);
        chk("R8", "illegal flag", err, 1);
        perf = 1'b0;
        tick(4);
        chk("R4", "low-power after legal code", pst, 3);
        chk("R8", "flag sticky", err, 1);
    endtask

    task automatic t_hibernate();
        hold = 1'b0;
        tick(4);
        chk("R4", "hibernate state", pst, 5);
        chk("R4", "hibernate rails", rail_en, 2);
        chk("R4", "hibernate fpwm", buck_fpwm, 0);
        chk("R4", "hibernate reset low", rst_low, 1);
        hold = 1'b1;
        tick(2);
        chk("R9", "before hold seen", pst, 5);
        tick(1);
        chk("R9", "restart on hold rise", pst, 1);
        chk("R9", "sequence restarts at first rail", rail_en, 1);
        tick(20);
        chk("R9", "resumed to low-power", pst, 3);
    endtask

    task automatic t_autorestart();
        hold = 1'b0;
        tick(4);
        chk("R4", "hibernate again", pst, 5);
        vin = 1'b0;
        tick(1);
        chk("R11", "supply loss forces off", pst, 0);
        chk("R11", "rails off", rail_en, 0);
        vin = 1'b1;
        tick(1);
        chk("R10", "auto restart", pst, 1);
        chk("R10", "wake starts", wake, 1);
        tick(WAKE_LEN - 1);
        chk("R10", "wake still high", wake, 1);
        tick(1);
        chk("R10", "wake ends", wake, 0);
        tick(20);
        chk("R10", "unconfirmed start ends off", pst, 0);
        chk("R3", "done cleared in off", sdone, 0);
        tick(10);
        chk("R10", "no retrigger", pst, 0);
        vin = 1'b0;
        tick(1);
        vin = 1'b1;
        lp = 1'b0;
        tick(1);
        chk("R10", "second auto restart wake", wake, 1);
        hold = 1'b1;
        tick(20);
        chk("R10", "confirmed start reaches active", pst, 2);
    endtask

    task automatic t_lp_first();
        vin = 1'b0;
        tick(1);
        lp = 1'b1;
        tick(3);
        vin = 1'b1;
        tick(1);
        chk("R5", "sequence entered", pst, 1);
        tick(5 * STEP);
        chk("R3", "done at last rail", sdone, 1);
        chk("R3", "still in seq", pst, 1);
        tick(1);
        chk("R5", "active first", pst, 2);
        tick(1);
        chk("R5", "then low-power", pst, 3);
    endtask

    task automatic t_unmask_clear();
        hold = 1'b0; lp = 1'b0;
        tick(4);
        chk("R4", "code 000 gives off", pst, 0);
        chk("R4", "off rails", rail_en, 0);
        en = 1'b0;
        tick(5);
        hold = 1'b1;
        tick(1);
        en = 1'b1;
        tick(30);
        chk("R7", "restart to active", pst, 2);
        perf = 1'b1;
        tick(4);
        chk("R7", "perf masked after enable fall", pst, 2);
        en = 1'b0;
        tick(2);
        chk("R11", "before enable seen", pst, 2);
        tick(1);
        chk("R11", "enable low forces off", pst, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_hpm_masked();
        t_unmask();
        t_illegal();
        t_hibernate();
        t_autorestart();
        t_lp_first();
        t_unmask_clear();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule